// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

This block places one storage stage in each direction between two 18-bit buses, A and B. Each stage has three ways of working. It can follow its input bus, it can hold a word, or it can capture a word on a rising edge of its own capture clock input. Its latch enable and its active-low clock enable choose between them. An active-low output enable on each direction decides whether that direction drives the far bus. Drive is shown as a data word plus an active-high drive-enable flag, so the block has no internal tri-states. The two directions share no state and behave the same way.

The block runs on one system clock. The per-direction capture clocks are treated as synchronous data inputs and are edge-detected against their value on the previous system clock. The stored word is a register, so a word that enters the block shows on the far port one system clock later. The drive flags are also registered and follow the output enables one clock later. The drive flags leave the stored data untouched.

Top module: `bidir_bus_reg`

## Requirements
- R1: While `rst` is high at a clock edge, both data outputs become zero and both drive flags become 0 after that edge.
- R2: When a direction's latch enable is 1 at a clock edge, that direction's output equals its input bus sampled at that edge from the next cycle on. Capture clock activity has no effect on this.
- R3: When the latch enable is 0 and no enabled rising capture edge occurs, the output keeps its value. This holds the word present when the latch enable was last 1.
- R4: A rising capture edge loads the input bus into the stage when three things are true at the same clock edge: the latch enable is 0, the clock enable is 0, and the capture input is 1 after having been 0 at the previous clock edge. The new word appears the next cycle.
- R5: With the clock enable at 1, rising capture edges load nothing.
- R6: A falling capture edge, or a capture input held high over several clocks, loads nothing.
- R7: The drive flag of a direction equals the inverse of its output enable sampled at the previous clock edge. The stored data keeps updating while the flag is 0.
- R8: Controls and data of one direction never change the other direction's output or drive flag.
- R9: A capture input that is already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | A bus, source for the A-to-B stage |
| b_in | input | 18 | B bus, source for the B-to-A stage |
| ab_le | input | 1 | A-to-B latch enable, 1 = follow |
| ab_tick | input | 1 | A-to-B capture clock input |
| ab_tick_en_n | input | 1 | A-to-B capture clock enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = follow |
| ba_tick | input | 1 | B-to-A capture clock input |
| ba_tick_en_n | input | 1 | B-to-A capture clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Word driven toward the B bus |
| b_out_en | output | 1 | B bus drive flag, 1 = driving |
| a_out | output | 18 | Word driven toward the A bus |
| a_out_en | output | 1 | A bus drive flag, 1 = driving |

## Verification
The hardest case is a capture edge whose condition spans two clock edges. The capture input must be low at one edge and high at the next, with the latch enable and clock enable low at the second edge. The input bus must also change just after, so that capture can be told apart from following. The bench builds the edge from separate steps: it lowers the input, then raises it together with a fresh data word, then replaces the word while the input stays high. It repeats the same sequence with the clock enable high, and again with the capture input already high when reset is released. The cases with no edge must then leave the old word in place.

// File: rtl/bbr_pkg.sv
package bbr_pkg;

  // What the storage stage does on the current system clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_FOLLOW  = 2'd1,
    ACT_CAPTURE = 2'd2
  } stage_act_e;

  // Control inputs of one direction.
  typedef struct packed {
    logic le;
    logic tick;
    logic tick_en_n;
    logic oe_n;
  } lane_ctl_t;

  localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/bbr_edge.sv
module bbr_edge (
  input  logic clk,
  input  logic tick,
  output logic rise
);

  logic tick_q;

  // The previous value tracks the input even during reset. A level that is
  // already high when reset ends therefore does not count as an edge.
  always_ff @(posedge clk) begin
    tick_q <= tick;
  end

  assign rise = tick & ~tick_q;

endmodule

// File: rtl/bbr_stage.sv
module bbr_stage
  import bbr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         rise,
  input  logic         tick_en_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  stage_act_e act;

  // Latch enable wins over the capture clock. An edge only counts when gated in.
  always_comb begin
    if (le)                      act = ACT_FOLLOW;
    else if (rise && !tick_en_n) act = ACT_CAPTURE;
    else                         act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (act)
        ACT_FOLLOW, ACT_CAPTURE: q <= din;
        default:                 q <= q;
      endcase
    end
  end

endmodule

// File: rtl/bbr_lane.sv
module bbr_lane
  import bbr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  lane_ctl_t    ctl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         drive
);

  logic rise;

  bbr_edge u_edge (
    .clk  (clk),
    .tick (ctl.tick),
    .rise (rise)
  );

  bbr_stage #(.W(W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .le        (ctl.le),
    .rise      (rise),
    .tick_en_n (ctl.tick_en_n),
    .din       (din),
    .q         (dout)
  );

  // The drive flag only gates the word; it never touches the stored data.
  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= ~ctl.oe_n;
  end

endmodule

// File: rtl/bidir_bus_reg.sv
module bidir_bus_reg
  import bbr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_le,
  input  logic         ab_tick,
  input  logic         ab_tick_en_n,
  input  logic         ab_oe_n,
  input  logic         ba_le,
  input  logic         ba_tick,
  input  logic         ba_tick_en_n,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_out_en,
  output logic [W-1:0] a_out,
  output logic         a_out_en
);

  // Lane 0 carries A to B, lane 1 carries B to A.
  lane_ctl_t          ctl   [NUM_LANES];
  logic [W-1:0]       src   [NUM_LANES];
  logic [W-1:0]       dst   [NUM_LANES];
  logic [NUM_LANES-1:0] drv;

  assign ctl[0] = '{le: ab_le, tick: ab_tick, tick_en_n: ab_tick_en_n, oe_n: ab_oe_n};
  assign ctl[1] = '{le: ba_le, tick: ba_tick, tick_en_n: ba_tick_en_n, oe_n: ba_oe_n};
  assign src[0] = a_in;
  assign src[1] = b_in;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    bbr_lane #(.W(W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .ctl   (ctl[g]),
      .din   (src[g]),
      .dout  (dst[g]),
      .drive (drv[g])
    );
  end

  assign b_out    = dst[0];
  assign b_out_en = drv[0];
  assign a_out    = dst[1];
  assign a_out_en = drv[1];

endmodule

// File: rtl/bbr_chk.sv
module bbr_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_le,
  input logic         ab_tick,
  input logic         ab_tick_en_n,
  input logic         ab_oe_n,
  input logic         ba_le,
  input logic         ba_tick,
  input logic         ba_tick_en_n,
  input logic         ba_oe_n,
  input logic [W-1:0] b_out,
  input logic         b_out_en,
  input logic [W-1:0] a_out,
  input logic         a_out_en
);

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (b_out == '0 && a_out == '0 && !b_out_en && !a_out_en)); // R1

  AST_AB_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    ab_le |=> b_out == $past(a_in)); // R2
  AST_BA_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    ba_le |=> a_out == $past(b_in)); // R2

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && (ab_tick_en_n || !ab_tick)) |=> $stable(b_out)); // R3
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && (ba_tick_en_n || !ba_tick)) |=> $stable(a_out)); // R3

  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && !ab_tick_en_n && ab_tick && !$past(ab_tick)) |=> b_out == $past(a_in)); // R4
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !ba_tick_en_n && ba_tick && !$past(ba_tick)) |=> a_out == $past(b_in)); // R4

  AST_AB_NO_FALSE_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!ab_le && ab_tick && $past(ab_tick)) |=> $stable(b_out)); // R6
  AST_BA_NO_FALSE_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && ba_tick && $past(ba_tick)) |=> $stable(a_out)); // R6

  AST_AB_DRIVE_ON: assert property (@(posedge clk) disable iff (rst)
    !ab_oe_n |=> b_out_en); // R7
  AST_AB_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst)
    ab_oe_n |=> !b_out_en); // R7
  AST_BA_DRIVE_ON: assert property (@(posedge clk) disable iff (rst)
    !ba_oe_n |=> a_out_en); // R7
  AST_BA_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst)
    ba_oe_n |=> !a_out_en); // R7

endmodule

bind bidir_bus_reg bbr_chk #(.W(W)) u_chk (.*);

// File: tb/bidir_bus_reg_tb.sv
module bidir_bus_reg_tb;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a_in, b_in;
  logic         ab_le, ab_tick, ab_tick_en_n, ab_oe_n;
  logic         ba_le, ba_tick, ba_tick_en_n, ba_oe_n;
  logic [W-1:0] b_out, a_out;
  logic         b_out_en, a_out_en;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  bidir_bus_reg #(.W(W)) u_dut (.*);

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // d = 0: A to B, d = 1: B to A
  task automatic set_ctl(input int d, input logic le, input logic tk,
                         input logic en_n, input logic oe_n);
    if (d == 0) begin ab_le = le; ab_tick = tk; ab_tick_en_n = en_n; ab_oe_n = oe_n; end
    else        begin ba_le = le; ba_tick = tk; ba_tick_en_n = en_n; ba_oe_n = oe_n; end
  endtask

  task automatic set_in(input int d, input logic [W-1:0] v);
    if (d == 0) a_in = v; else b_in = v;
  endtask

  function automatic logic [W-1:0] get_out(input int d);
    return (d == 0) ? b_out : a_out;
  endfunction

  function automatic logic get_en(input int d);
    return (d == 0) ? b_out_en : a_out_en;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    a_in = 18'h3ffff; b_in = 18'h3ffff;
    set_ctl(0, 1, 0, 0, 0); set_ctl(1, 1, 0, 0, 0);
    do_reset();
    // still in the first cycle after release: reset values
    chk("R1 b_out", b_out, '0);
    chk("R1 a_out", a_out, '0);
    chk("R1 b_out_en", {17'd0, b_out_en}, '0);
    chk("R1 a_out_en", {17'd0, a_out_en}, '0);
  endtask

  task automatic t_follow(input int d);
    set_ctl(d, 1, 0, 1, 0);
    set_in(d, 18'h12345); step();
    chk("R2 follow 1", get_out(d), 18'h12345);
    set_in(d, 18'h2abcd);
    set_ctl(d, 1, 1, 0, 0); step(); // capture edge while following
    chk("R2 follow with edge", get_out(d), 18'h2abcd);
    set_in(d, 18'h00f0f); step();
    chk("R2 follow 3", get_out(d), 18'h00f0f);
  endtask

  task automatic t_hold(input int d);
    set_ctl(d, 1, 0, 0, 0); set_in(d, 18'h15a5a); step();
    set_ctl(d, 0, 0, 0, 0); set_in(d, 18'h0ffff); step();
    chk("R3 hold after le fall", get_out(d), 18'h15a5a);
    set_in(d, 18'h30001); step(3);
    chk("R3 hold steady", get_out(d), 18'h15a5a);
  endtask

  task automatic t_capture(input int d);
    set_ctl(d, 0, 0, 0, 0); set_in(d, 18'h00111); step();
    set_ctl(d, 0, 1, 0, 0); set_in(d, 18'h2c0de); step();
    chk("R4 capture", get_out(d), 18'h2c0de);
    set_in(d, 18'h11111); step(2); // tick held high
    chk("R6 high level no capture", get_out(d), 18'h2c0de);
    set_ctl(d, 0, 0, 0, 0); set_in(d, 18'h22222); step();
    chk("R6 falling edge no capture", get_out(d), 18'h2c0de);
  endtask

  task automatic t_gated(input int d);
    set_ctl(d, 0, 0, 1, 0); set_in(d, 18'h0aaaa); step();
    set_ctl(d, 0, 1, 1, 0); step();
    chk("R5 gated edge ignored", get_out(d), 18'h2c0de);
    set_ctl(d, 0, 0, 1, 0); step();
    set_ctl(d, 0, 1, 0, 0); step(); // enabled edge
    chk("R5 enabled edge after gate", get_out(d), 18'h0aaaa);
  endtask

  task automatic t_oe(input int d);
    set_ctl(d, 1, 0, 0, 1); set_in(d, 18'h01234); step();
    chk("R7 drive off", {17'd0, get_en(d)}, '0);
    chk("R7 data updates while off", get_out(d), 18'h01234);
    set_ctl(d, 0, 0, 0, 0); step();
    chk("R7 drive on", {17'd0, get_en(d)}, 18'd1);
    chk("R7 data unchanged by oe", get_out(d), 18'h01234);
  endtask

  task automatic t_indep();
    set_ctl(0, 0, 0, 1, 0); set_ctl(1, 1, 0, 1, 1);
    a_in = 18'h00a0a; b_in = 18'h0b0b0; step();
    chk("R8 B-to-A follows", a_out, 18'h0b0b0);
    chk("R8 B-to-A drive off", {17'd0, a_out_en}, '0);
    b_in = 18'h3c3c3; set_ctl(0, 1, 0, 1, 0); step();
    chk("R8 A-to-B follows", b_out, 18'h00a0a);
    chk("R8 A-to-B drive on", {17'd0, b_out_en}, 18'd1);
    chk("R8 B-to-A independent", a_out, 18'h3c3c3);
  endtask

  task automatic t_reset_high_tick(input int d);
    rst = 1'b1;
    set_ctl(d, 0, 1, 0, 0); set_in(d, 18'h3dead & 18'h3ffff);
    step(2);
    rst = 1'b0; step(2);
    chk("R9 high tick at release", get_out(d), '0);
    set_ctl(d, 0, 0, 0, 0); step();
    set_ctl(d, 0, 1, 0, 0); set_in(d, 18'h04321); step();
    chk("R9 first real edge", get_out(d), 18'h04321);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    a_in = '0; b_in = '0;
    set_ctl(0, 0, 0, 1, 1); set_ctl(1, 0, 0, 1, 1);
    step();
    t_reset();
    for (int d = 0; d < 2; d++) begin
      t_follow(d);
      t_hold(d);
      t_capture(d);
      t_gated(d);
      t_oe(d);
    end
    t_indep();
    for (int d = 0; d < 2; d++) t_reset_high_tick(d);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule